// File: doc/BRIEF.md
# Evaluation Stack Top Cache with Automatic Spill and Fill

This block keeps the top of an evaluation stack for a zero-address machine. The newest entries, up to four of them, sit in registers. Older entries live in a word-wide backing memory. The block moves entries to and from that memory by itself, and the requester never issues an instruction for this traffic. A requester holds a request with `req_valid`. The request completes on the rising edge where `req_ready` is also high. While a spill or fill is in flight, `req_ready` stays low.

Push takes its data from the request's immediate field. Duplicate copies the top entry. Swap exchanges the two newest entries. A binary operation shows the two newest entries on `next_q` (older) and `top_q` (newer), then takes `alu_res` back as the single replacement entry. A branch request tests the top entry against zero with a signed condition, reports the outcome on `br_taken` and pops the entry. Popping more entries than exist, counting both on-chip and spilled entries, raises `err_underflow` and leaves the stack untouched.

Top module: `stk_top_cache`

## Requirements
- R1: At most four entries (parameter DEPTH) are held on chip. Operations that stay within that count cause no memory traffic.
- R2: A push or duplicate that finds four entries on chip first writes the oldest on-chip entry to memory at the spill pointer address. The spill pointer then increments, and the request completes afterwards.
- R3: While a spill or fill is outstanding (`mem_req` high), `req_ready` is low. The stalled request completes only after the memory acknowledges.
- R4: Binary operation (req_op=5): `top_q` is the newest entry and `next_q` is the one below it. On completion both are replaced by `alu_res`, and the stack shrinks by one.
- R5: Push (req_op=1) places `req_imm` on top. Every other operation ignores `req_imm`.
- R6: Duplicate (req_op=3) pushes a copy of the top entry.
- R7: Branch (req_op=6) compares the top entry, taken as signed, against zero. The conditions are `req_cc` 0 = equal, 1 = not equal, 2 = less, 3 = greater, 4 = less or equal, 5 = greater or equal. The result shows on `br_taken` in the completing cycle, and the entry is popped. Pop is req_op=2 and no-op is req_op=0.
- R8: Swap (req_op=4) exchanges the two newest entries, so a following binary subtract yields older minus newer.
- R9: When an operation needs more entries than are on chip and memory holds spilled entries, the block reads memory at spill pointer minus one before operating. The most recently spilled entry is filled first and becomes the oldest on-chip entry, and the pointer decrements.
- R10: An operation that needs more entries than the on-chip and spilled entries combined completes at once with `err_underflow` high in that cycle, and the stack is left unchanged.
- R11: After reset the stack is empty: `top_valid` is low, `mem_req` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_op | input | 3 | Operation code |
| req_imm | input | 32 | Immediate for push |
| req_cc | input | 3 | Branch condition code |
| req_ready | output | 1 | Request completes this cycle when high |
| alu_res | input | 32 | Result returned for a binary operation |
| top_q | output | 32 | Newest on-chip entry |
| next_q | output | 32 | Second newest on-chip entry |
| top_valid | output | 1 | At least one entry on chip |
| br_taken | output | 1 | Branch condition true for a completing branch |
| err_underflow | output | 1 | Completing request underflowed the stack |
| mem_req | output | 1 | Memory access outstanding |
| mem_we | output | 1 | Access is a spill write |
| mem_addr | output | 8 | Memory word address |
| mem_wdata | output | 32 | Spilled entry |
| mem_rdata | input | 32 | Filled entry |
| mem_ack | input | 1 | One-cycle completion of the memory access |

## Verification
The bench drives a push past four entries and a duplicate at full occupancy. A design that spilled the wrong end of the array, or spilled without stalling, would leave wrong words in the memory model or return a wrong top. It then drains the chip and issues a swap that needs two fills. If fills ran in the wrong order, the following subtract would produce the negated difference. The bench steps the branch conditions through zero, positive and negative values, where unsigned compares or a missing pop show up at once. It also pops an empty stack and applies a binary operation to a single entry. A design that changed state on underflow would then show a different top afterwards.

// File: rtl/stk_pkg.sv
package stk_pkg;
   typedef enum logic [2:0] {
      OP_NOP = 3'd0, OP_PUSH = 3'd1, OP_POP = 3'd2, OP_DUP = 3'd3,
      OP_SWAP = 3'd4, OP_BIN = 3'd5, OP_BRANCH = 3'd6, OP_RSV = 3'd7
   } stk_op_e;

   typedef enum logic [2:0] {
      CC_EQ = 3'd0, CC_NE = 3'd1, CC_LT = 3'd2, CC_GT = 3'd3,
      CC_LE = 3'd4, CC_GE = 3'd5, CC_R6 = 3'd6, CC_R7 = 3'd7
   } stk_cc_e;

   typedef enum logic [2:0] {
      RF_HOLD, RF_PUSH, RF_POP, RF_SWAP, RF_MERGE, RF_APPEND, RF_DROP
   } rf_cmd_e;

   typedef enum logic [1:0] {MC_IDLE, MC_SPILL, MC_FILL} mc_state_e;
endpackage

// File: rtl/stk_regfile.sv
module stk_regfile
   import stk_pkg::*;
#(
   parameter int DW    = 32,
   parameter int DEPTH = 4,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  rf_cmd_e       cmd,
   input  logic [DW-1:0] din,
   output logic [DW-1:0] ent [DEPTH],
   output logic [CW-1:0] cnt
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("stk_regfile: DEPTH must be at least 2");
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [DW-1:0] up_v, dn_v, nxt;
      if (i == 0) begin : g_up_in
         assign up_v = din;
      end else begin : g_up_nb
         assign up_v = ent[i-1];
      end
      if (i == DEPTH - 1) begin : g_dn_zero
         assign dn_v = '0;
      end else begin : g_dn_nb
         assign dn_v = ent[i+1];
      end

      always_comb begin
         nxt = ent[i];
         unique case (cmd)
            RF_PUSH:   nxt = up_v;
            RF_POP:    nxt = dn_v;
            RF_SWAP:   nxt = (i == 0) ? dn_v : ((i == 1) ? up_v : ent[i]);
            RF_MERGE:  nxt = (i == 0) ? din : dn_v;
            RF_APPEND: nxt = (CW'(i) == cnt) ? din : ent[i];
            default:   nxt = ent[i];
         endcase
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ent[i] <= '0;
         else        ent[i] <= nxt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else begin
         unique case (cmd)
            RF_PUSH, RF_APPEND:        cnt <= cnt + 1'b1;
            RF_POP, RF_MERGE, RF_DROP: cnt <= cnt - 1'b1;
            default:                   cnt <= cnt;
         endcase
      end
   end

   assert_append_room_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == RF_APPEND) |-> (cnt < CW'(DEPTH)));
   assert_push_room_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == RF_PUSH) |-> (cnt < CW'(DEPTH)));
endmodule

// File: rtl/stk_cond.sv
module stk_cond
   import stk_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic [DW-1:0] val,
   input  logic [2:0]    cc,
   output logic          hit
);
   logic zero, neg;
   assign zero = (val == '0);
   assign neg  = val[DW-1];

   always_comb begin
      unique case (stk_cc_e'(cc))
         CC_EQ:   hit = zero;
         CC_NE:   hit = !zero;
         CC_LT:   hit = neg;
         CC_GT:   hit = !neg && !zero;
         CC_LE:   hit = neg || zero;
         CC_GE:   hit = !neg;
         default: hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/stk_mem_ctl.sv
module stk_mem_ctl
   import stk_pkg::*;
#(
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_spill,
   input  logic          start_fill,
   input  logic          mem_ack,
   output logic          idle,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [AW-1:0] sp,
   output logic          spill_done,
   output logic          fill_done
);
   mc_state_e st;

   assign idle       = (st == MC_IDLE);
   assign mem_req    = !idle;
   assign mem_we     = (st == MC_SPILL);
   assign mem_addr   = mem_we ? sp : sp - 1'b1;
   assign spill_done = (st == MC_SPILL) && mem_ack;
   assign fill_done  = (st == MC_FILL) && mem_ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= MC_IDLE;
         sp <= '0;
      end else begin
         unique case (st)
            MC_IDLE:  if (start_spill) st <= MC_SPILL;
                      else if (start_fill) st <= MC_FILL;
            MC_SPILL: if (mem_ack) begin st <= MC_IDLE; sp <= sp + 1'b1; end
            MC_FILL:  if (mem_ack) begin st <= MC_IDLE; sp <= sp - 1'b1; end
            default:  st <= MC_IDLE;
         endcase
      end
   end

   assert_spill_ptr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      spill_done |=> (sp == $past(sp) + 1'b1));
   assert_fill_ptr_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fill_done |=> (sp == $past(sp) - 1'b1));
   assert_one_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(start_spill && start_fill));
endmodule

// File: rtl/stk_top_cache.sv
module stk_top_cache
   import stk_pkg::*;
#(
   parameter int DW    = 32,
   parameter int DEPTH = 4,
   parameter int AW    = 8,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [2:0]    req_op,
   input  logic [DW-1:0] req_imm,
   input  logic [2:0]    req_cc,
   output logic          req_ready,
   input  logic [DW-1:0] alu_res,
   output logic [DW-1:0] top_q,
   output logic [DW-1:0] next_q,
   output logic          top_valid,
   output logic          br_taken,
   output logic          err_underflow,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   input  logic          mem_ack
);
   if (AW + 1 < CW) begin : g_bad_aw
      $error("stk_top_cache: AW too small for DEPTH");
   end

   stk_op_e       op;
   rf_cmd_e       rf_cmd;
   logic [DW-1:0] rf_din;
   logic [DW-1:0] ent [DEPTH];
   logic [CW-1:0] cnt;
   logic [AW-1:0] sp;
   logic          idle, spill_done, fill_done, cond_hit;
   logic [1:0]    need;
   logic          grows, uflow, need_spill, need_fill, fire;
   logic [AW:0]   avail;

   assign op = stk_op_e'(req_op);

   always_comb begin
      unique case (op)
         OP_POP, OP_DUP, OP_BRANCH: need = 2'd1;
         OP_SWAP, OP_BIN:           need = 2'd2;
         default:                   need = 2'd0;
      endcase
   end

   assign grows      = (op == OP_PUSH) || (op == OP_DUP);
   assign avail      = {1'b0, sp} + (AW+1)'(cnt);
   assign uflow      = (AW+1)'(need) > avail;
   assign need_fill  = !uflow && (CW'(need) > cnt);
   assign need_spill = grows && (cnt == CW'(DEPTH));
   assign req_ready  = idle && !(req_valid && (need_fill || need_spill));
   assign fire       = req_valid && req_ready;

   always_comb begin
      rf_cmd = RF_HOLD;
      rf_din = req_imm;
      if (spill_done) rf_cmd = RF_DROP;
      else if (fill_done) begin
         rf_cmd = RF_APPEND;
         rf_din = mem_rdata;
      end else if (fire && !uflow) begin
         unique case (op)
            OP_PUSH:           rf_cmd = RF_PUSH;
            OP_DUP:            begin rf_cmd = RF_PUSH; rf_din = ent[0]; end
            OP_POP, OP_BRANCH: rf_cmd = RF_POP;
            OP_SWAP:           rf_cmd = RF_SWAP;
            OP_BIN:            begin rf_cmd = RF_MERGE; rf_din = alu_res; end
            default:           rf_cmd = RF_HOLD;
         endcase
      end
   end

   stk_regfile #(.DW(DW), .DEPTH(DEPTH)) u_rf (
      .clk(clk), .rst_n(rst_n), .cmd(rf_cmd), .din(rf_din), .ent(ent), .cnt(cnt)
   );

   stk_mem_ctl #(.AW(AW)) u_mc (
      .clk(clk), .rst_n(rst_n),
      .start_spill(idle && req_valid && need_spill),
      .start_fill(idle && req_valid && need_fill),
      .mem_ack(mem_ack), .idle(idle), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .sp(sp), .spill_done(spill_done), .fill_done(fill_done)
   );

   stk_cond #(.DW(DW)) u_cc (.val(ent[0]), .cc(req_cc), .hit(cond_hit));

   assign top_q         = ent[0];
   assign next_q        = ent[1];
   assign top_valid     = (cnt != '0);
   assign mem_wdata     = ent[DEPTH-1];
   assign br_taken      = fire && !uflow && (op == OP_BRANCH) && cond_hit;
   assign err_underflow = fire && uflow;

   assert_onchip_max_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH));
   assert_spill_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> (cnt == CW'(DEPTH)));
   assert_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !req_ready);
   assert_uflow_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      err_underflow |=> ($stable(cnt) && $stable(sp)));
   assert_fill_room_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |-> (cnt < CW'(DEPTH)));
endmodule

// File: tb/stk_top_cache_tb.sv
`timescale 1ns/1ps
module stk_top_cache_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  req_op = 3'd0;
   logic [31:0] req_imm = '0;
   logic [2:0]  req_cc = 3'd0;
   logic        req_ready, top_valid, br_taken, err_underflow;
   logic [31:0] alu_res, top_q, next_q, mem_wdata;
   logic        mem_req, mem_we;
   logic [7:0]  mem_addr;
   logic [31:0] mem_rdata = '0;
   logic        mem_ack = 1'b0;

   int total = 0, bad = 0;
   int wr_cnt = 0, rd_cnt = 0, dly = 0;
   logic [31:0] mem [16];

   always #5 clk = ~clk;

   assign alu_res = next_q - top_q;

   stk_top_cache u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_imm(req_imm), .req_cc(req_cc), .req_ready(req_ready),
      .alu_res(alu_res), .top_q(top_q), .next_q(next_q), .top_valid(top_valid),
      .br_taken(br_taken), .err_underflow(err_underflow), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_ack(mem_ack)
   );

   always @(posedge clk) begin
      mem_ack <= 1'b0;
      if (mem_req && !mem_ack) begin
         if (dly == 1) begin
            mem_ack <= 1'b1;
            dly <= 0;
            if (mem_we) begin
               mem[mem_addr[3:0]] <= mem_wdata;
               wr_cnt <= wr_cnt + 1;
            end else begin
               mem_rdata <= mem[mem_addr[3:0]];
               rd_cnt <= rd_cnt + 1;
            end
         end else dly <= dly + 1;
      end
   end

   typedef struct packed {
      logic [2:0]  op;
      logic [31:0] imm;
      logic [2:0]  cc;
      logic [31:0] etop;
      logic        chk;
      logic        ebr;
      logic        eerr;
   } vec_t;

   localparam int NV = 23;
   localparam vec_t VEC [NV] = '{
      '{3'd1, 32'd10,        3'd0, 32'd10,        1'b1, 1'b0, 1'b0},
      '{3'd1, 32'd3,         3'd0, 32'd3,         1'b1, 1'b0, 1'b0},
      '{3'd5, 32'hAAAA5555,  3'd0, 32'd7,         1'b1, 1'b0, 1'b0},
      '{3'd1, 32'd20,        3'd0, 32'd20,        1'b1, 1'b0, 1'b0},
      '{3'd1, 32'd5,         3'd0, 32'd5,         1'b1, 1'b0, 1'b0},
      '{3'd1, 32'd6,         3'd0, 32'd6,         1'b1, 1'b0, 1'b0},
      '{3'd1, 32'd8,         3'd0, 32'd8,         1'b1, 1'b0, 1'b0},
      '{3'd3, 32'hDEADBEEF,  3'd0, 32'd8,         1'b1, 1'b0, 1'b0},
      '{3'd5, 32'd0,         3'd0, 32'd0,         1'b1, 1'b0, 1'b0},
      '{3'd6, 32'd0,         3'd0, 32'd6,         1'b1, 1'b1, 1'b0},
      '{3'd4, 32'd99,        3'd0, 32'd5,         1'b1, 1'b0, 1'b0},
      '{3'd5, 32'd0,         3'd0, 32'd1,         1'b1, 1'b0, 1'b0},
      '{3'd6, 32'd0,         3'd3, 32'd0,         1'b0, 1'b1, 1'b0},
      '{3'd4, 32'd0,         3'd0, 32'd7,         1'b1, 1'b0, 1'b0},
      '{3'd5, 32'd0,         3'd0, 32'd13,        1'b1, 1'b0, 1'b0},
      '{3'd6, 32'd0,         3'd2, 32'd0,         1'b0, 1'b0, 1'b0},
      '{3'd2, 32'd0,         3'd0, 32'd0,         1'b0, 1'b0, 1'b1},
      '{3'd1, 32'hFFFFFFFF,  3'd0, 32'hFFFFFFFF,  1'b1, 1'b0, 1'b0},
      '{3'd6, 32'd0,         3'd5, 32'd0,         1'b0, 1'b0, 1'b0},
      '{3'd1, 32'd0,         3'd0, 32'd0,         1'b1, 1'b0, 1'b0},
      '{3'd6, 32'd0,         3'd4, 32'd0,         1'b0, 1'b1, 1'b0},
      '{3'd1, 32'd4,         3'd0, 32'd4,         1'b1, 1'b0, 1'b0},
      '{3'd6, 32'd0,         3'd1, 32'd0,         1'b0, 1'b1, 1'b0}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_op(input logic [2:0] op, input logic [31:0] imm, input logic [2:0] cc,
                        output logic br, output logic er, output int stalls);
      req_valid = 1'b1; req_op = op; req_imm = imm; req_cc = cc;
      stalls = 0;
      #1;
      while (!req_ready && stalls < 200) begin
         stalls++;
         @(negedge clk);
      end
      br = br_taken;
      er = err_underflow;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      req_valid = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      #1_000_000;
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic br, er;
      int st;
      do_reset();
      // R11: reset state
      check("R11 top_valid", {31'd0, top_valid}, 32'd0);
      check("R11 mem_req", {31'd0, mem_req}, 32'd0);
      check("R11 req_ready", {31'd0, req_ready}, 32'd1);

      for (int k = 0; k < NV; k++) begin
         do_op(VEC[k].op, VEC[k].imm, VEC[k].cc, br, er, st);
         // R4 R5 R6 R8: top after each step
         if (VEC[k].chk) check($sformatf("R4/R5/R6/R8 step%0d top", k), top_q, VEC[k].etop);
         // R7: branch outcome
         if (VEC[k].op == 3'd6) check($sformatf("R7 step%0d br", k), {31'd0, br}, {31'd0, VEC[k].ebr});
         // R10: underflow flag
         check($sformatf("R10 step%0d err", k), {31'd0, er}, {31'd0, VEC[k].eerr});
         if (k == 5) check("R1 no traffic at four entries", wr_cnt, 0);
         if (k == 6) check("R3 push stalls on spill", {31'd0, st > 0}, 32'd1);
         if (k == 7) begin
            check("R2 spill count", wr_cnt, 2);
            check("R2 first spill word", mem[0], 32'd7);
            check("R2 second spill word", mem[1], 32'd20);
         end
         if (k == 12) check("R7 pop leaves chip empty", {31'd0, top_valid}, 32'd0);
         if (k == 13) begin
            check("R9 fill count", rd_cnt, 2);
            check("R9 fill order next", next_q, 32'd20);
            check("R3 swap stalls on fill", {31'd0, st > 1}, 32'd1);
         end
         if (k == 16) check("R10 empty after underflow", {31'd0, top_valid}, 32'd0);
      end

      // R10: binary op on a single entry underflows and keeps it
      do_op(3'd2, 32'd0, 3'd0, br, er, st);
      do_op(3'd1, 32'd55, 3'd0, br, er, st);
      do_op(3'd5, 32'd0, 3'd0, br, er, st);
      check("R10 binop underflow flag", {31'd0, er}, 32'd1);
      check("R10 top kept", top_q, 32'd55);
      check("R10 still valid", {31'd0, top_valid}, 32'd1);

      // R11: reset mid-stream empties the stack
      do_op(3'd1, 32'd66, 3'd0, br, er, st);
      do_reset();
      check("R11 empty after reset", {31'd0, top_valid}, 32'd0);
      do_op(3'd2, 32'd0, 3'd0, br, er, st);
      check("R11 pop after reset underflows", {31'd0, er}, 32'd1);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule